// File: doc/BRIEF.md
# Snooping Line-State Coherence Fabric

This block keeps a set of small private caches coherent over one shared snoop bus. Each cache has its own controller, which holds a tag, a one-word data value and two state bits (a shared bit and an exclusive bit) for every line of a directly indexed store. A request from the local processor that the store can satisfy is answered straight away. Any other request is sent out on the bus, marked either as a read for sharing or as a locked (exclusive) acquisition. All the other controllers look up the broadcast address in their own stores. A peer that holds the line supplies the word, so main memory is skipped. Otherwise the word is read from memory. Each store then moves to its new state.

A peer whose processor is holding the requested line exclusive while a locked operation is under way answers with a stall instead. The requester drops back and retries until the lock is released. Only one transaction occupies the bus in any cycle. When several controllers want the bus together, a fixed-priority arbiter picks one. A probe address lets the surrounding logic read every controller's state for one line.

Top module: `coh_snoop_fabric`

## Requirements
- R1: After reset, every line in every controller reads as invalid (state 2'b00) on `probe_state`, and `busy`, `resp_valid`, `stalled` and `mem_rd_en` are all low.
- R2: A local hit needs no bus transaction and no memory read. A local hit is either a shared request to a line held shared or exclusive, or an exclusive request to a line held exclusive. Its `resp_valid` pulse carries the stored word with `resp_peer` low.
- R3: If a request misses locally and no peer holds the line, `mem_rd_en` is high for exactly one cycle with `mem_addr` equal to the request address. The response carries `mem_rdata` with `resp_peer` low. The requester then holds the line shared (2'b01) after a shared request, or exclusive (2'b10) after an exclusive request.
- R4: If a shared request hits in one or more peers, the word comes from a peer (`resp_peer` high) and memory is not read. Afterwards the requester and every peer that held the line read as shared (2'b01).
- R5: If an exclusive request hits in peers, those peers become invalid (2'b00) and the requester becomes exclusive (2'b10). The word comes from a peer and memory is not read.
- R6: A peer stalls the request if it holds the requested line exclusive while its `lock_hold` is high with `lock_addr` equal to that address. The requester's `stalled` output then stays high and no response or memory read happens until the lock drops. After that the request completes as in R4 or R5. A lock on a different address causes no stall.
- R7: If several controllers need the bus in the same cycle, the one with the lowest index is served first. Each of the others keeps requesting until it is granted, one cycle later per rank.
- R8: At no time do two controllers hold the same line exclusive, and no line ever holds both state bits set (2'b11).
- R9: An uncontended miss produces its response pulse three cycles after the request is sampled. A local hit produces its pulse one cycle after.
- R10: A miss whose index is occupied by a different tag replaces that line, so the old address then reads as invalid in that controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NC | Per-controller request strobe, sampled while that controller is idle |
| req_excl | input | NC | Request type per controller: 1 exclusive (locked), 0 shared |
| req_addr | input | NC*AW | Per-controller line address, controller i in bits [i*AW +: AW] |
| lock_hold | input | NC | Per-controller flag: a locked operation is under way |
| lock_addr | input | NC*AW | Per-controller address of the line under the locked operation |
| busy | output | NC | Controller has a miss outstanding |
| resp_valid | output | NC | One-cycle response pulse |
| resp_data | output | NC*DW | Response word per controller |
| resp_peer | output | NC | Response word came from a peer cache |
| stalled | output | NC | Outstanding miss was stalled by a locked peer line |
| mem_rd_en | output | 1 | Main memory read in this cycle |
| mem_addr | output | AW | Address of the memory read |
| mem_rdata | input | DW | Memory word for `mem_addr`, same cycle |
| probe_addr | input | AW | Line address to observe |
| probe_state | output | NC*2 | State of `probe_addr` per controller, {exclusive, shared} |

## Verification
The hardest situation to reach is the locked-line stall. It needs a peer that already owns the line exclusive, a lock raised on that exact address, and then a request for the line from another controller. A directed sequence builds this step by step. It keeps the lock up for several cycles, then releases it, and it also shows that a lock on a neighbouring address has no effect. Same-cycle contention is also directed. The rest is a long seeded random stream over a small address pool that aliases on the index. This stream produces sharing, upgrades, invalidations and replacements, and each one is checked against a reference model of every store in the bench.

// File: rtl/coh_pkg.sv
package coh_pkg;

    // Per-line coherence state: {excl, shr}. 2'b11 is illegal.
    typedef struct packed {
        logic excl;
        logic shr;
    } lstate_t;

    localparam lstate_t LS_INV = 2'b00;
    localparam lstate_t LS_SHR = 2'b01;
    localparam lstate_t LS_EXC = 2'b10;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_REQ  = 2'd1,
        CT_WAIT = 2'd2
    } ctl_e;

    function automatic logic st_valid(lstate_t s);
        return s.excl | s.shr;
    endfunction

    // State the requester installs after its miss completes.
    function automatic lstate_t fill_state(logic excl_req);
        return excl_req ? LS_EXC : LS_SHR;
    endfunction

    // State a snooping holder moves to after another cache's request.
    function automatic lstate_t snoop_next(lstate_t cur, logic excl_req);
        if (excl_req)
            return LS_INV;
        return st_valid(cur) ? LS_SHR : cur;
    endfunction

endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter #(
    parameter int N  = 2,
    parameter int SW = 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          grant_any,
    output logic [SW-1:0] grant_idx
);
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                found     = 1'b1;
                grant[i]  = 1'b1;
                grant_idx = SW'(i);
            end
        end
        grant_any = found;
    end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
    import coh_pkg::*;
#(
    parameter int AW = 5,
    parameter int IW = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    // local side
    input  logic          req_valid,
    input  logic          req_excl,
    input  logic [AW-1:0] req_addr,
    input  logic          lock_hold,
    input  logic [AW-1:0] lock_addr,
    output logic          busy,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data,
    output logic          resp_peer,
    output logic          stalled,
    // bus request side
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] my_addr,
    output logic          my_excl,
    // broadcast and snoop side
    input  logic          bus_vld,
    input  logic          bus_excl,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_mine,
    output logic          snp_hit,
    output logic [DW-1:0] snp_data,
    output logic          snp_stall,
    input  logic          all_hit,
    input  logic [DW-1:0] all_data,
    input  logic          all_stall,
    input  logic [DW-1:0] mem_rdata,
    // observation
    input  logic [AW-1:0] probe_addr,
    output lstate_t       probe_state
);
    localparam int NL = 1 << IW;
    localparam int TW = AW - IW;

    logic [TW-1:0] tag_q [NL];
    lstate_t       st_q  [NL];
    logic [DW-1:0] dat_q [NL];

    ctl_e          fsm_q;
    logic [AW-1:0] pend_addr_q;
    logic          pend_excl_q;
    logic          stalled_q;
    logic          resp_valid_q;
    logic [DW-1:0] resp_data_q;
    logic          resp_peer_q;

    // local lookup
    logic [IW-1:0] l_idx;
    logic [TW-1:0] l_tag;
    lstate_t       l_st;
    logic          l_hit;

    always_comb begin
        l_idx = req_addr[IW-1:0];
        l_tag = req_addr[AW-1:IW];
        l_st  = st_q[l_idx];
        l_hit = (tag_q[l_idx] == l_tag) && (l_st.excl || (l_st.shr && !req_excl));
    end

    // snoop lookup
    logic [IW-1:0] s_idx;
    logic [TW-1:0] s_tag;
    lstate_t       s_st;
    logic          s_match;

    always_comb begin
        s_idx     = bus_addr[IW-1:0];
        s_tag     = bus_addr[AW-1:IW];
        s_st      = st_q[s_idx];
        s_match   = bus_vld && !bus_mine && st_valid(s_st) && (tag_q[s_idx] == s_tag);
        snp_hit   = s_match;
        snp_data  = s_match ? dat_q[s_idx] : '0;
        snp_stall = s_match && s_st.excl && lock_hold && (lock_addr == bus_addr);
    end

    // pending miss
    logic [IW-1:0] p_idx;
    logic [TW-1:0] p_tag;
    logic [DW-1:0] fill_data;

    always_comb begin
        p_idx     = pend_addr_q[IW-1:0];
        p_tag     = pend_addr_q[AW-1:IW];
        fill_data = all_hit ? all_data : mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q        <= CT_IDLE;
            pend_addr_q  <= '0;
            pend_excl_q  <= 1'b0;
            stalled_q    <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            resp_peer_q  <= 1'b0;
            for (int i = 0; i < NL; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LS_INV;
                dat_q[i] <= '0;
            end
        end else begin
            resp_valid_q <= 1'b0;
            case (fsm_q)
                CT_IDLE: begin
                    if (req_valid) begin
                        if (l_hit) begin
                            resp_valid_q <= 1'b1;
                            resp_data_q  <= dat_q[l_idx];
                            resp_peer_q  <= 1'b0;
                        end else begin
                            pend_addr_q <= req_addr;
                            pend_excl_q <= req_excl;
                            fsm_q       <= CT_REQ;
                        end
                    end
                end
                CT_REQ: begin
                    if (bus_grant)
                        fsm_q <= CT_WAIT;
                end
                CT_WAIT: begin
                    if (all_stall) begin
                        fsm_q     <= CT_REQ;
                        stalled_q <= 1'b1;
                    end else begin
                        fsm_q        <= CT_IDLE;
                        stalled_q    <= 1'b0;
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= fill_data;
                        resp_peer_q  <= all_hit;
                        tag_q[p_idx] <= p_tag;
                        st_q[p_idx]  <= fill_state(pend_excl_q);
                        dat_q[p_idx] <= fill_data;
                    end
                end
                default: fsm_q <= CT_IDLE;
            endcase
            // A snoop never targets the requester's own transaction.
            if (s_match && !all_stall)
                st_q[s_idx] <= snoop_next(s_st, bus_excl);
        end
    end

    always_comb begin
        busy        = (fsm_q != CT_IDLE);
        bus_req     = (fsm_q == CT_REQ);
        my_addr     = pend_addr_q;
        my_excl     = pend_excl_q;
        resp_valid  = resp_valid_q;
        resp_data   = resp_data_q;
        resp_peer   = resp_peer_q;
        stalled     = stalled_q;
        probe_state = (tag_q[probe_addr[IW-1:0]] == probe_addr[AW-1:IW])
                      ? st_q[probe_addr[IW-1:0]] : LS_INV;
    end

    // R6: a stalled transaction goes back to requesting with no response
    assert_stall_retries_R6: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == CT_WAIT && all_stall) |=> (fsm_q == CT_REQ && stalled && !resp_valid));

    // R9: while waiting, the broadcast in flight is this controller's own
    assert_wait_owns_bus_R9: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == CT_WAIT) |-> (bus_vld && bus_mine));

    for (genvar g = 0; g < NL; g++) begin : g_line_chk
        // R8: the illegal encoding never appears
        assert_legal_state_R8: assert property (@(posedge clk) disable iff (rst)
            !(st_q[g].excl && st_q[g].shr));
        // R5: an exclusive snoop hit leaves the line invalid here
        assert_excl_snoop_inval_R5: assert property (@(posedge clk) disable iff (rst)
            (s_match && bus_excl && !all_stall && s_idx == IW'(g)) |=> (st_q[g] == LS_INV));
    end

endmodule

// File: rtl/coh_snoop_fabric.sv
module coh_snoop_fabric
    import coh_pkg::*;
#(
    parameter int NC = 3,
    parameter int AW = 5,
    parameter int IW = 2,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NC-1:0]   req_valid,
    input  logic [NC-1:0]   req_excl,
    input  logic [NC*AW-1:0] req_addr,
    input  logic [NC-1:0]   lock_hold,
    input  logic [NC*AW-1:0] lock_addr,
    output logic [NC-1:0]   busy,
    output logic [NC-1:0]   resp_valid,
    output logic [NC*DW-1:0] resp_data,
    output logic [NC-1:0]   resp_peer,
    output logic [NC-1:0]   stalled,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [AW-1:0]   probe_addr,
    output logic [NC*2-1:0] probe_state
);
    localparam int SW = (NC > 2) ? $clog2(NC) : 1;

    logic [NC-1:0]   bus_req;
    logic [NC-1:0]   grant;
    logic            grant_any;
    logic [SW-1:0]   grant_idx;
    logic [AW-1:0]   my_addr_a [NC];
    logic [NC-1:0]   my_excl;
    logic [NC-1:0]   snp_hit;
    logic [NC-1:0]   snp_stall;
    logic [DW-1:0]   snp_data_a [NC];
    logic [NC-1:0]   probe_excl;

    logic            bus_vld_q;
    logic            bus_excl_q;
    logic [AW-1:0]   bus_addr_q;
    logic [SW-1:0]   bus_src_q;

    logic            all_hit;
    logic            all_stall;
    logic [DW-1:0]   all_data;

    coh_arbiter #(.N(NC), .SW(SW)) u_arb (
        .req       (bus_req),
        .grant     (grant),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    for (genvar i = 0; i < NC; i++) begin : g_ctrl
        lstate_t pst;
        coh_ctrl #(.AW(AW), .IW(IW), .DW(DW)) u_ctrl (
            .clk         (clk),
            .rst         (rst),
            .req_valid   (req_valid[i]),
            .req_excl    (req_excl[i]),
            .req_addr    (req_addr[i*AW +: AW]),
            .lock_hold   (lock_hold[i]),
            .lock_addr   (lock_addr[i*AW +: AW]),
            .busy        (busy[i]),
            .resp_valid  (resp_valid[i]),
            .resp_data   (resp_data[i*DW +: DW]),
            .resp_peer   (resp_peer[i]),
            .stalled     (stalled[i]),
            .bus_req     (bus_req[i]),
            .bus_grant   (grant[i]),
            .my_addr     (my_addr_a[i]),
            .my_excl     (my_excl[i]),
            .bus_vld     (bus_vld_q),
            .bus_excl    (bus_excl_q),
            .bus_addr    (bus_addr_q),
            .bus_mine    (bus_src_q == SW'(i)),
            .snp_hit     (snp_hit[i]),
            .snp_data    (snp_data_a[i]),
            .snp_stall   (snp_stall[i]),
            .all_hit     (all_hit),
            .all_data    (all_data),
            .all_stall   (all_stall),
            .mem_rdata   (mem_rdata),
            .probe_addr  (probe_addr),
            .probe_state (pst)
        );
        assign probe_state[i*2 +: 2] = pst;
        assign probe_excl[i]         = pst.excl;

        // R7: a request that loses arbitration stays raised
        assert_loser_holds_R7: assert property (@(posedge clk) disable iff (rst)
            (bus_req[i] && !grant[i]) |=> bus_req[i]);
    end

    // Snoop responses are OR-combined across all controllers.
    always_comb begin
        all_data = '0;
        for (int i = 0; i < NC; i++)
            all_data = all_data | snp_data_a[i];
        all_hit   = |snp_hit;
        all_stall = |snp_stall;
        mem_rd_en = bus_vld_q && !all_hit && !all_stall;
        mem_addr  = bus_addr_q;
    end

    // One broadcast slot, loaded from the granted controller.
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_vld_q  <= 1'b0;
            bus_excl_q <= 1'b0;
            bus_addr_q <= '0;
            bus_src_q  <= '0;
        end else begin
            bus_vld_q <= grant_any;
            if (grant_any) begin
                bus_excl_q <= my_excl[grant_idx];
                bus_addr_q <= my_addr_a[grant_idx];
                bus_src_q  <= grant_idx;
            end
        end
    end

    // R8: no two controllers own the probed line exclusive
    assert_single_owner_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(probe_excl));

    // R7: never more than one grant per cycle
    assert_one_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3: a memory read is followed by a non-peer response to the requester
    logic [SW-1:0] chk_src_q;
    always_ff @(posedge clk) begin
        if (rst) chk_src_q <= '0;
        else     chk_src_q <= bus_src_q;
    end

    assert_mem_fill_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (resp_valid[chk_src_q] && !resp_peer[chk_src_q]));

endmodule

// File: tb/test_coh_snoop_fabric.sv
module test_coh_snoop_fabric;
    localparam int NC = 3;
    localparam int AW = 5;
    localparam int IW = 2;
    localparam int DW = 16;
    localparam int NL = 1 << IW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0]    req_valid = '0;
    logic [NC-1:0]    req_excl = '0;
    logic [NC*AW-1:0] req_addr = '0;
    logic [NC-1:0]    lock_hold = '0;
    logic [NC*AW-1:0] lock_addr = '0;
    logic [NC-1:0]    busy;
    logic [NC-1:0]    resp_valid;
    logic [NC*DW-1:0] resp_data;
    logic [NC-1:0]    resp_peer;
    logic [NC-1:0]    stalled;
    logic             mem_rd_en;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_rdata;
    logic [AW-1:0]    probe_addr = '0;
    logic [NC*2-1:0]  probe_state;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    coh_snoop_fabric #(.NC(NC), .AW(AW), .IW(IW), .DW(DW)) i_coh_snoop_fabric (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_excl(req_excl), .req_addr(req_addr),
        .lock_hold(lock_hold), .lock_addr(lock_addr),
        .busy(busy), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_peer(resp_peer), .stalled(stalled),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .probe_addr(probe_addr), .probe_state(probe_state)
    );

    function automatic logic [DW-1:0] mem_f(logic [AW-1:0] a);
        return DW'(a) * 16'h0133 + 16'h0F1D;
    endfunction

    always_comb mem_rdata = mem_f(mem_addr);

    // reference model of every store: tag and state per index
    int m_tag [NC][NL];
    int m_st  [NC][NL];

    function automatic int exp_state(int c, logic [AW-1:0] a);
        int ix = int'(a[IW-1:0]);
        return (m_tag[c][ix] == int'(a[AW-1:IW])) ? m_st[c][ix] : 0;
    endfunction

    function automatic bit exp_local_hit(int c, bit ex, logic [AW-1:0] a);
        int s = exp_state(c, a);
        return (s == 2) || (s == 1 && !ex);
    endfunction

    function automatic bit exp_peer_hit(int c, logic [AW-1:0] a);
        bit h = 0;
        for (int k = 0; k < NC; k++)
            if (k != c && exp_state(k, a) != 0) h = 1;
        return h;
    endfunction

    function automatic void model_miss(int c, bit ex, logic [AW-1:0] a);
        int ix = int'(a[IW-1:0]);
        for (int k = 0; k < NC; k++) begin
            if (k != c && exp_state(k, a) != 0)
                m_st[k][ix] = ex ? 0 : 1;
        end
        m_tag[c][ix] = int'(a[AW-1:IW]);
        m_st[c][ix]  = ex ? 2 : 1;
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // compare every controller's state for one address with the model
    task automatic probe_all(input string rq, input logic [AW-1:0] a);
        int owners;
        probe_addr = a;
        #1;
        owners = 0;
        for (int k = 0; k < NC; k++) begin
            check(rq, "line state", 32'(probe_state[k*2 +: 2]), 32'(exp_state(k, a)));
            if (probe_state[k*2 +: 2] == 2'b10) owners++;
            if (probe_state[k*2 +: 2] == 2'b11) owners += 2;
        end
        check("R8", "exclusive owners", 32'(owners > 1), 32'd0);
    endtask

    // issue one request and wait for its response
    task automatic issue(input int c, input bit ex, input logic [AW-1:0] a,
                         output int lat, output int mreads, output bit peer,
                         output logic [DW-1:0] d, output bit saw_stall);
        @(negedge clk);
        req_valid[c] = 1'b1;
        req_excl[c]  = ex;
        req_addr[c*AW +: AW] = a;
        @(negedge clk);
        req_valid[c] = 1'b0;
        lat = 1; mreads = 0; saw_stall = 0;
        while (!resp_valid[c] && lat < 60) begin
            if (mem_rd_en) begin
                mreads++;
                check("R3", "memory address", 32'(mem_addr), 32'(a));
            end
            if (stalled[c]) saw_stall = 1;
            @(negedge clk);
            lat++;
        end
        peer = resp_peer[c];
        d    = resp_data[c*DW +: DW];
    endtask

    task automatic run_one(input int c, input bit ex, input logic [AW-1:0] a);
        bit lh, ph, peer, st;
        int lat, mr;
        logic [DW-1:0] d;
        lh = exp_local_hit(c, ex, a);
        ph = exp_peer_hit(c, a);
        issue(c, ex, a, lat, mr, peer, d, st);
        check("R9", "latency", 32'(lat), lh ? 32'd1 : 32'd3);
        check(lh ? "R2" : "R3", "data", 32'(d), 32'(mem_f(a)));
        check(ph && !lh ? (ex ? "R5" : "R4") : "R2", "peer flag", 32'(peer), 32'(ph && !lh));
        check(ph || lh ? "R4" : "R3", "memory reads", 32'(mr), (ph || lh) ? 32'd0 : 32'd1);
        if (!lh) model_miss(c, ex, a);
        probe_all(ex ? "R5" : "R4", a);
        probe_all("R10", a ^ (AW'(1) << IW));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int lat0, lat2, lat, mr;
        bit peer, st;
        logic [DW-1:0] d;
        void'($urandom(32'd1357));
        for (int k = 0; k < NC; k++)
            for (int j = 0; j < NL; j++) begin
                m_tag[k][j] = 0;
                m_st[k][j]  = 0;
            end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "resp_valid", 32'(resp_valid), 32'd0);
        check("R1", "stalled", 32'(stalled), 32'd0);
        check("R1", "mem_rd_en", 32'(mem_rd_en), 32'd0);
        for (int a = 0; a < 8; a++) probe_all("R1", AW'(a));

        // R7: simultaneous misses from controllers 0 and 2
        @(negedge clk);
        req_valid = 3'b101; req_excl = '0;
        req_addr[0 +: AW] = AW'(1);
        req_addr[2*AW +: AW] = AW'(2);
        lat0 = 0; lat2 = 0;
        for (int t = 1; t <= 8; t++) begin
            @(negedge clk);
            req_valid = '0;
            if (resp_valid[0] && lat0 == 0) lat0 = t;
            if (resp_valid[2] && lat2 == 0) lat2 = t;
        end
        check("R7", "lowest index latency", 32'(lat0), 32'd3);
        check("R7", "higher index latency", 32'(lat2), 32'd4);
        model_miss(0, 0, AW'(1));
        model_miss(2, 0, AW'(2));
        probe_all("R7", AW'(1));
        probe_all("R7", AW'(2));

        // R6: locked exclusive line stalls a peer
        run_one(1, 1, AW'(5));
        lock_hold[1] = 1'b1;
        lock_addr[1*AW +: AW] = AW'(5);
        @(negedge clk);
        req_valid[0] = 1'b1; req_excl[0] = 1'b0; req_addr[0 +: AW] = AW'(5);
        mr = 0;
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            req_valid[0] = 1'b0;
            if (mem_rd_en) mr++;
            check("R6", "no response while locked", 32'(resp_valid[0]), 32'd0);
        end
        check("R6", "stalled flag", 32'(stalled[0]), 32'd1);
        check("R6", "memory reads while locked", 32'(mr), 32'd0);
        lock_hold[1] = 1'b0;
        lat = 0;
        while (!resp_valid[0] && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R6", "response after release", 32'(resp_valid[0]), 32'd1);
        check("R6", "peer supplied", 32'(resp_peer[0]), 32'd1);
        check("R6", "data", 32'(resp_data[0 +: DW]), 32'(mem_f(AW'(5))));
        model_miss(0, 0, AW'(5));
        probe_all("R6", AW'(5));
        @(negedge clk);
        check("R6", "stalled cleared", 32'(stalled[0]), 32'd0);

        // R6: lock on a different address does not stall
        run_one(1, 1, AW'(6));
        lock_hold[1] = 1'b1;
        lock_addr[1*AW +: AW] = AW'(7);
        issue(2, 1, AW'(6), lat, mr, peer, d, st);
        check("R6", "unrelated lock latency", 32'(lat), 32'd3);
        check("R6", "unrelated lock stall", 32'(st), 32'd0);
        check("R5", "peer flag", 32'(peer), 32'd1);
        model_miss(2, 1, AW'(6));
        probe_all("R5", AW'(6));
        lock_hold[1] = 1'b0;

        // random traffic over an aliasing address pool
        for (int n = 0; n < 400; n++) begin
            int c;
            bit ex;
            logic [AW-1:0] a;
            c  = int'($urandom_range(NC - 1, 0));
            ex = ($urandom_range(2, 0) == 0);
            a  = AW'($urandom_range(15, 0));
            run_one(c, ex, a);
        end

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule